// File: doc/BRIEF.md
# Two-Slow Interleaved Dual-Channel Recursive Filter

This block runs the second-order recursion y(n) = x(n) + a*y(n-2) for two independent sample streams on one adder and one multiplier. The streams share a single input port on alternating clocks: one clock carries a sample of channel 0, the next carries a sample of channel 1, and so on. Each delay of the single-stream recursion is doubled, so the feedback loop holds four registers. A value computed for one channel therefore returns to the adder exactly when the same channel's sample two positions back is needed. The clocks in between serve the other channel with the same hardware.

A one-bit channel tag enters with each sample and leaves with its result after a fixed two-cycle latency. The consumer can therefore steer outputs without counting slots. A build-time option moves one loop register from in front of the multiplier to behind it. This shortens the combinational path to a single operation per stage and does not change any output value. Results clamp to the largest or smallest value of the sample width rather than wrap. The coefficient is signed fixed point with a configurable number of fraction bits.

Top module: `iir2s_filter`

## Requirements
- R1: While reset is high, every loop register is cleared, so out_sample and out_chan read 0 after a reset edge. After reset the first output of each channel equals its first input, because both channels' feedback starts at zero.
- R2: For channel c and that channel's n-th sample, the output is sat(x_c(n) + floor(a*y_c(n-2) / 2^COEF_FRAC)). Here a is coef_a read as a signed two's-complement number, and y_c(n-2) is the output of the same channel two of its own samples earlier, which is four clocks earlier on the shared port.
- R3: The sum saturates at the signed DATA_W range, [-2^(DATA_W-1), 2^(DATA_W-1)-1]. It never wraps: two non-negative terms never give a negative result, and two negative terms never give a non-negative result.
- R4: A sample presented with in_chan at a rising edge gives its result on out_sample two rising edges later. At that point out_chan equals the in_chan value of that sample. Channel 0 is tag 0 and channel 1 is tag 1.
- R5: The channels are independent: an input on one channel never changes the other channel's outputs.
- R6: The retimed build (RETIME=1, product register behind the multiplier) and the plain build (RETIME=0) give identical outputs for identical inputs, provided the coefficient is held constant between resets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_sample | input | DATA_W | Signed input sample of the channel in the current slot |
| in_chan | input | 1 | Channel tag of in_sample (0 or 1), alternating every clock |
| coef_a | input | COEF_W | Signed feedback coefficient with COEF_FRAC fraction bits |
| out_sample | output | DATA_W | Registered signed filter output |
| out_chan | output | 1 | Channel tag of out_sample |

## Verification
A single impulse on channel 0, with zeros elsewhere, separates the two-sample lag of the recursion from a one-sample or four-sample lag. It also shows any leakage into channel 1, which must stay at zero. Long runs of full-scale inputs of opposite sign on the two channels, with a coefficient near one, drive both channels into the positive and negative clamps. Under those inputs a wrapping adder gives the wrong sign. Seeded random samples with random positive and negative coefficients, checked against two separate per-channel models, expose rounding-direction errors in the coefficient scaling. Both the retimed and the plain build run side by side on every vector.

// File: rtl/iir2s_pkg.sv
package iir2s_pkg;

  // Number of interleaved streams sharing the datapath.
  localparam int unsigned SLOW_FACTOR = 2;

  typedef enum logic {
    CHAN_ZERO = 1'b0,
    CHAN_ONE  = 1'b1
  } chan_e;

endpackage

// File: rtl/iir2s_delay_line.sv
// Register chain of DEPTH stages with synchronous clear.
module iir2s_delay_line #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [WIDTH-1:0] d,
  output logic signed [WIDTH-1:0] q
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic signed [WIDTH-1:0] stage [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage[gi] <= '0;
        end else if (gi == 0) begin
          stage[gi] <= d;
        end else begin
          stage[gi] <= stage[(gi == 0) ? 0 : gi - 1];
        end
      end
    end
  endgenerate

  assign q = stage[DEPTH-1];

  // Fill counter: saturates at DEPTH once DEPTH edges have passed out of reset.
  logic [CW-1:0] fill;
  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
    end else if (fill != CW'(DEPTH)) begin
      fill <= fill + 1'b1;
    end
  end

  // R2: the tap seen by the loop is the value written DEPTH clocks earlier
  assert_tap_delay_R2: assert property (@(posedge clk) disable iff (rst)
    (fill == CW'(DEPTH)) |-> (q == $past(d, DEPTH)));

endmodule

// File: rtl/iir2s_coef_mult.sv
// Signed coefficient multiply with arithmetic scaling, optionally registered.
module iir2s_coef_mult #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned COEF_W    = 16,
  parameter int unsigned COEF_FRAC = 14,
  parameter bit          OUT_REG   = 1'b1,
  localparam int unsigned PROD_W   = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [PROD_W-1:0] scaled
);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] prod_sh;

  always_comb begin
    prod    = PROD_W'(sample) * PROD_W'(coef);
    prod_sh = prod >>> COEF_FRAC;
  end

  generate
    if (OUT_REG) begin : g_reg
      logic signed [PROD_W-1:0] scaled_q;
      always_ff @(posedge clk) begin
        if (rst) scaled_q <= '0;
        else     scaled_q <= prod_sh;
      end
      assign scaled = scaled_q;

      // R2: sign of the registered product follows the operands of the previous clock
      assert_prod_sign_reg_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(sample[DATA_W-1]) && !$past(coef[COEF_W-1])) |-> !scaled[PROD_W-1]);
    end else begin : g_comb
      assign scaled = prod_sh;

      // R2: two non-negative operands give a non-negative scaled product
      assert_prod_sign_comb_R2: assert property (@(posedge clk) disable iff (rst)
        (!sample[DATA_W-1] && !coef[COEF_W-1]) |-> !scaled[PROD_W-1]);
    end
  endgenerate

endmodule

// File: rtl/iir2s_sat_add.sv
// Adds a DATA_W sample to a wider feedback term and clamps to DATA_W.
module iir2s_sat_add #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WIDE_W = 32,
  localparam int unsigned SUM_W = WIDE_W + 1
) (
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [WIDE_W-1:0] fb,
  output logic signed [DATA_W-1:0] y
);

  localparam logic signed [SUM_W-1:0] MAX_V = {{(SUM_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MIN_V = {{(SUM_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [SUM_W-1:0] wide_sum;

  always_comb begin
    wide_sum = SUM_W'(x) + SUM_W'(fb);
    if (wide_sum > MAX_V)      y = MAX_V[DATA_W-1:0];
    else if (wide_sum < MIN_V) y = MIN_V[DATA_W-1:0];
    else                       y = wide_sum[DATA_W-1:0];
  end

  always_comb begin
    if (!x[DATA_W-1] && !fb[WIDE_W-1]) begin
      assert_no_wrap_pos_R3: assert (!y[DATA_W-1]);
    end
    if (x[DATA_W-1] && fb[WIDE_W-1]) begin
      assert_no_wrap_neg_R3: assert (y[DATA_W-1]);
    end
  end

endmodule

// File: rtl/iir2s_filter.sv
// Two-slow, two-channel interleaved recursive filter.
module iir2s_filter #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned COEF_W    = 16,
  parameter int unsigned COEF_FRAC = 14,
  parameter int unsigned FB_LAG    = 2,
  parameter bit          RETIME    = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic                     in_chan,
  input  logic signed [COEF_W-1:0] coef_a,
  output logic signed [DATA_W-1:0] out_sample,
  output logic                     out_chan
);

  import iir2s_pkg::*;

  localparam int unsigned PROD_W   = DATA_W + COEF_W;
  // Every single-stream delay is multiplied by the slow factor.
  localparam int unsigned LOOP_LEN = SLOW_FACTOR * FB_LAG;
  // One loop register is the output register y_q; RETIME moves one behind the multiplier.
  localparam int unsigned TAP_LEN  = LOOP_LEN - 1 - (RETIME ? 1 : 0);

  logic signed [DATA_W-1:0] x_q;
  chan_e                    c_q;
  logic signed [DATA_W-1:0] y_q;
  logic                     oc_q;
  logic signed [DATA_W-1:0] tap;
  logic signed [PROD_W-1:0] fb_term;
  logic signed [DATA_W-1:0] sum;

  // Input capture stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      c_q <= CHAN_ZERO;
    end else begin
      x_q <= in_sample;
      c_q <= chan_e'(in_chan);
    end
  end

  iir2s_delay_line #(
    .WIDTH (DATA_W),
    .DEPTH (TAP_LEN)
  ) tap_i (
    .clk (clk),
    .rst (rst),
    .d   (y_q),
    .q   (tap)
  );

  iir2s_coef_mult #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .COEF_FRAC (COEF_FRAC),
    .OUT_REG   (RETIME)
  ) mult_i (
    .clk    (clk),
    .rst    (rst),
    .sample (tap),
    .coef   (coef_a),
    .scaled (fb_term)
  );

  iir2s_sat_add #(
    .DATA_W (DATA_W),
    .WIDE_W (PROD_W)
  ) add_i (
    .x  (x_q),
    .fb (fb_term),
    .y  (sum)
  );

  // Output stage: this register is also the first loop register.
  always_ff @(posedge clk) begin
    if (rst) begin
      y_q  <= '0;
      oc_q <= 1'b0;
    end else begin
      y_q  <= sum;
      oc_q <= c_q;
    end
  end

  assign out_sample = y_q;
  assign out_chan   = oc_q;

  // Cycles since reset, saturating at 2, for latency checks.
  logic [1:0] age;
  logic       rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)              age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R4: tag leaves two clocks after it entered
  assert_chan_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_chan == $past(in_chan, 2)));

  // R1: a reset edge leaves the outputs cleared
  always_ff @(posedge clk) begin
    if (rst_d) begin
      assert_reset_clear_R1: assert (out_sample == '0 && out_chan == 1'b0);
    end
  end

endmodule

// File: tb/iir2s_filter_tb.sv
`timescale 1ns/1ps
module iir2s_filter_tb_top;

  localparam int DW   = 16;
  localparam int CW   = 16;
  localparam int FRAC = 14;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [DW-1:0] in_sample = '0;
  logic in_chan = 1'b0;
  logic signed [CW-1:0] coef_a = '0;
  logic signed [DW-1:0] out_r, out_p;
  logic chan_r, chan_p;

  always #2.5 clk = ~clk;

  iir2s_filter #(.DATA_W(DW), .COEF_W(CW), .COEF_FRAC(FRAC), .RETIME(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_sample(in_sample), .in_chan(in_chan), .coef_a(coef_a),
    .out_sample(out_r), .out_chan(chan_r));

  iir2s_filter #(.DATA_W(DW), .COEF_W(CW), .COEF_FRAC(FRAC), .RETIME(1'b0)) dut_plain_i (
    .clk(clk), .rst(rst), .in_sample(in_sample), .in_chan(in_chan), .coef_a(coef_a),
    .out_sample(out_p), .out_chan(chan_p));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Per-channel model state: hist[c][0] = y(n-1), hist[c][1] = y(n-2).
  logic signed [DW-1:0] hist [2][2];
  // Expected-value pipeline, two slots.
  bit                   pv [2];
  logic signed [DW-1:0] pe [2];
  logic                 pc [2];
  string                pr [2];
  logic                 ch_next = 1'b0;

  function automatic logic signed [DW-1:0] model_step(logic signed [DW-1:0] x,
      logic signed [CW-1:0] a, logic signed [DW-1:0] yp);
    longint p, s;
    p = longint'(a) * longint'(yp);
    p = p >>> FRAC;
    s = longint'(x) + p;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return DW'(s);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic signed [DW-1:0] x, input string req);
    logic signed [DW-1:0] y;
    @(negedge clk);
    if (pv[1]) begin
      check(pr[1], out_r, pe[1]);
      check("R6", out_p, pe[1]);
      check("R4", chan_r, pc[1]);
      check("R4", chan_p, pc[1]);
    end
    pv[1] = pv[0]; pe[1] = pe[0]; pc[1] = pc[0]; pr[1] = pr[0];
    rst = 1'b0;
    in_sample = x;
    in_chan   = ch_next;
    y = model_step(x, coef_a, hist[ch_next][1]);
    hist[ch_next][1] = hist[ch_next][0];
    hist[ch_next][0] = y;
    pv[0] = 1'b1; pe[0] = y; pc[0] = ch_next; pr[0] = req;
    ch_next = ~ch_next;
  endtask

  task automatic do_reset(input logic signed [CW-1:0] a);
    step('0, "R2");
    step('0, "R2");
    @(negedge clk);
    if (pv[1]) begin
      check(pr[1], out_r, pe[1]);
      check("R6", out_p, pe[1]);
      check("R4", chan_r, pc[1]);
    end
    rst = 1'b1;
    in_sample = '0;
    in_chan = 1'b0;
    coef_a = a;
    repeat (2) @(negedge clk);
    // R1: outputs cleared by reset
    check("R1", out_r, 0);
    check("R1", out_p, 0);
    check("R1", chan_r, 0);
    for (int c = 0; c < 2; c++) begin
      hist[c][0] = '0;
      hist[c][1] = '0;
      pv[c] = 1'b0;
    end
    ch_next = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 2; c++) begin
      hist[c][0] = '0; hist[c][1] = '0; pv[c] = 1'b0; pe[c] = '0; pc[c] = 1'b0; pr[c] = "";
    end
    repeat (3) @(negedge clk);
    // R1: outputs are zero during the initial reset
    check("R1", out_r, 0);
    check("R1", chan_r, 0);

    // R5 and R2: impulse on channel 0, channel 1 held at zero, a = 0.5
    do_reset(16'sd8192);
    step(16'sd16000, "R1");
    step(16'sd0, "R5");
    for (int i = 0; i < 20; i++) begin
      step(16'sd0, "R2");
      step(16'sd0, "R5");
    end

    // R5: impulse on channel 1 only, negative coefficient
    do_reset(-16'sd10000);
    step(16'sd0, "R5");
    step(-16'sd12345, "R1");
    for (int i = 0; i < 20; i++) begin
      step(16'sd0, "R5");
      step(16'sd0, "R2");
    end

    // R3: saturation in both directions, coefficient near one
    do_reset(16'sd16383);
    for (int i = 0; i < 40; i++) begin
      step(16'sd30000, "R3");
      step(-16'sd30000, "R3");
    end
    do_reset(-16'sd16384);
    for (int i = 0; i < 40; i++) begin
      step(16'sd32767, "R3");
      step(16'sd32767, "R3");
    end

    // R2: random coefficients and samples
    for (int ph = 0; ph < 8; ph++) begin
      do_reset(CW'($urandom_range(0, 32767)) - 16'sd16384);
      for (int i = 0; i < 400; i++) begin
        if (ph[0]) step(DW'($urandom), "R2");
        else       step(DW'($urandom_range(0, 4000)) - 16'sd2000, "R2");
      end
    end

    do_reset('0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule